// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits behind the parallel pixel bus of an image sensor. Each pixel-clock cycle it takes a pixel word, a horizontal sync, a vertical sync and a field flag. It decides which pixels, lines, fields and frames go downstream. Both sync polarities and the pixel-clock sampling edge are programmable. The capture sequencer handles progressive frames and interlaced video. For interlaced video it grabs one field or a pair of fields, starting on a top field, a bottom field or the next field to arrive. It runs either once per start request or continuously, and in continuous mode it can drop a programmed number of vertical-sync periods between captures.

Narrow samples are widened to the output width and left-aligned. The freed low bits are filled with zeros or with a copy of the sample's top bits. A row window and a column window, each with its own enable, can crop the image. The result is a valid-qualified pixel stream with a start marker on the first pixel and an end marker on the last pixel of every captured field or frame. All configuration arrives on plain input ports and must be held steady while a capture is in progress.

Top module: `cam_par_capture`

## Requirements
- R1: After reset `out_valid`, `out_sof`, `out_eof` and `done` are low. No pixel is delivered until a `start` pulse arms the block, and a `start` pulse that arrives while the block is already armed has no effect.
- R2: `cfg_mode` selects the capture unit. 0 = progressive frame. 1 = two fields beginning on a top field. 2 = two fields beginning on a bottom field. 3 = two fields beginning on the next field. 4 = one top field. 5 = one bottom field. 6 = one field, the next one. Code 7 behaves as 0. The second field of a pair is always the field that immediately follows the first.
- R3: With `cfg_fpol` = 0, `field_in` = 0 marks a top field and 1 marks a bottom field. With `cfg_fpol` = 1 the meaning is swapped. The flag is taken when the vertical sync becomes active.
- R4: A pixel is taken when both syncs are at their active levels. `cfg_vpol` and `cfg_hpol` each select active-high (0) or active-low (1) for their own sync.
- R5: `cfg_ppol` = 0 samples the bus on the rising clock edge and `cfg_ppol` = 1 samples it on the falling edge. The selection is registered, and both choices give the same latency.
- R6: With `cfg_cont` = 0 the block captures one unit, pulses `done` for one cycle together with the unit's final end marker, and then ignores later fields until the next `start`.
- R7: With `cfg_cont` = 1 units are captured repeatedly and `done` stays low. After each unit, the next `cfg_skip` vertical-sync periods are dropped before a new unit may begin.
- R8: `cfg_bps` gives the sample width. 0 = 12, 1 = 11, 2 = 10, 3 = 9, 4 = 8 bits, and codes 5 to 7 mean 8 bits. The sample sits in the low bits of `pix_in`, and the pin bits above it have no effect. The sample is placed at the top of `out_data`.
- R9: The low `out_data` bits freed by a narrow sample are 0 when `cfg_rep` = 0. When `cfg_rep` = 1 they repeat the sample's most significant bits, so the sample's top bit lands in the highest freed position.
- R10: Lines are numbered from 0 within each field, and pixels are numbered from 0 within each line. With a crop enable set, only rows (columns) from `cfg_row_lo` (`cfg_col_lo`) to `cfg_row_hi` (`cfg_col_hi`), both ends inclusive, are passed. With the enable clear, all rows (columns) are passed.
- R11: `out_sof` marks the first delivered pixel of each captured field or frame. `out_eof` marks the last one. Each captured field or frame that keeps at least one pixel gives exactly one of each marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse for a capture |
| cfg_mode | input | 3 | Capture unit selection |
| cfg_fpol | input | 1 | Field flag meaning |
| cfg_ppol | input | 1 | Sampling edge, 1 = falling |
| cfg_vpol | input | 1 | Vertical sync active low when 1 |
| cfg_hpol | input | 1 | Horizontal sync active low when 1 |
| cfg_cont | input | 1 | Continuous capture when 1 |
| cfg_bps | input | 3 | Sample width code |
| cfg_rep | input | 1 | Fill freed bits from sample top bits |
| cfg_skip | input | SKIP_W | Sync periods dropped between units |
| cfg_row_en | input | 1 | Row crop enable |
| cfg_col_en | input | 1 | Column crop enable |
| cfg_row_lo | input | CNT_W | First kept row |
| cfg_row_hi | input | CNT_W | Last kept row |
| cfg_col_lo | input | CNT_W | First kept column |
| cfg_col_hi | input | CNT_W | Last kept column |
| pix_in | input | OUT_W | Sensor pixel bus |
| vsync_in | input | 1 | Vertical sync |
| hsync_in | input | 1 | Horizontal sync |
| field_in | input | 1 | Interlace field flag |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | OUT_W | Widened pixel |
| out_sof | output | 1 | First pixel of a captured field or frame |
| out_eof | output | 1 | Last pixel of a captured field or frame |
| done | output | 1 | One-cycle pulse at the end of a single-shot capture |

## Verification
The bench runs every mode code against three-field sequences under both field meanings. A sequencer that tested field parity on the wrong side of the polarity bit would grab the wrong field, and a pair mode that checked parity again on its second field would stop after one field and never raise `done`. Continuous runs with a skip count expose an off-by-one in the drop counter, because the captured fields would no longer be every third one. Each crop edge is checked to be inclusive, and the end marker is checked to land on the final kept pixel, not on a pixel one late or one early. Width codes are driven with junk in the pin bits above the sample, and a bus value is changed between the two clock edges, so a wrong shift, a wrong fill source or an ignored edge select shows up as a wrong output word.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

   typedef enum logic [2:0] {
      CAP_PROG      = 3'd0,
      CAP_PAIR_TOP  = 3'd1,
      CAP_PAIR_BOT  = 3'd2,
      CAP_PAIR_NEXT = 3'd3,
      CAP_ONE_TOP   = 3'd4,
      CAP_ONE_BOT   = 3'd5,
      CAP_ONE_NEXT  = 3'd6,
      CAP_RSVD      = 3'd7
   } cap_mode_e;

   // number of pixel bits dropped from the full width for a width code
   function automatic int narrow_by(input logic [2:0] code);
      return (code > 3'd4) ? 4 : int'(code);
   endfunction

endpackage

// File: rtl/cpf_sampler.sv
module cpf_sampler #(
   parameter int DW      = 12,
   parameter bit FALL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ppol,
   input  logic [DW-1:0] d_in,
   input  logic          vs_in,
   input  logic          hs_in,
   input  logic          fld_in,
   output logic [DW-1:0] d_q,
   output logic          vs_q,
   output logic          hs_q,
   output logic          fld_q
);
   localparam int BW = DW + 3;

   logic [BW-1:0] live;
   logic [BW-1:0] pick;

   assign live = {d_in, vs_in, hs_in, fld_in};

   generate
      if (FALL_EN) begin : g_fall
         logic          ppol_q;
         logic [BW-1:0] neg_q;

         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) neg_q <= '0;
            else        neg_q <= live;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ppol_q <= 1'b0;
            else        ppol_q <= ppol;
         end

         // falling-edge copy was taken half a cycle earlier: same latency
         assign pick = ppol_q ? neg_q : live;
      end else begin : g_rise
         assign pick = live;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) {d_q, vs_q, hs_q, fld_q} <= '0;
      else        {d_q, vs_q, hs_q, fld_q} <= pick;
   end

endmodule

// File: rtl/cpf_seq.sv
module cpf_seq
   import cpf_pkg::*;
#(
   parameter int SKIP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic              cont,
   input  logic [SKIP_W-1:0] skip_cfg,
   input  logic              is_top,
   input  logic              fstart,
   input  logic              fend,
   output logic              cap_now,
   output logic              done
);
   logic              armed_q;
   logic              cap_q;
   logic [1:0]        left_q;
   logic [SKIP_W-1:0] skip_q;
   logic              done_q;
   logic              match;
   logic              pair;
   logic              take;

   always_comb begin
      match = 1'b1;
      pair  = 1'b0;
      unique case (cap_mode_e'(mode))
         CAP_PAIR_TOP:  begin match = is_top;  pair = 1'b1; end
         CAP_PAIR_BOT:  begin match = !is_top; pair = 1'b1; end
         CAP_PAIR_NEXT: begin match = 1'b1;    pair = 1'b1; end
         CAP_ONE_TOP:   match = is_top;
         CAP_ONE_BOT:   match = !is_top;
         default:       match = 1'b1;
      endcase
   end

   // second field of a pair is taken unconditionally
   assign take    = armed_q && fstart &&
                    ((left_q != 2'd0) || ((skip_q == '0) && match));
   assign cap_now = fstart ? take : cap_q;
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cap_q   <= 1'b0;
         left_q  <= 2'd0;
         skip_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !armed_q) begin
            armed_q <= 1'b1;
            left_q  <= 2'd0;
            skip_q  <= '0;
         end
         if (fstart && armed_q) begin
            if (take) begin
               cap_q <= 1'b1;
               if (left_q == 2'd0) left_q <= pair ? 2'd2 : 2'd1;
            end else if ((left_q == 2'd0) && (skip_q != '0)) begin
               skip_q <= skip_q - 1'b1;
            end
         end
         if (fend && cap_q) begin
            cap_q  <= 1'b0;
            left_q <= left_q - 2'd1;
            if (left_q == 2'd1) begin
               if (cont) begin
                  skip_q <= skip_cfg;
               end else begin
                  armed_q <= 1'b0;
                  done_q  <= 1'b1;
               end
            end
         end
      end
   end

   // R2
   cap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_q) |-> $past(fstart));

   // R6
   done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !armed_q);

   // R7
   skip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_q != '0) |-> !cap_q);

endmodule

// File: rtl/cpf_window.sv
module cpf_window #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vact,
   input  logic             hact,
   input  logic             row_en,
   input  logic             col_en,
   input  logic [CNT_W-1:0] row_lo,
   input  logic [CNT_W-1:0] row_hi,
   input  logic [CNT_W-1:0] col_lo,
   input  logic [CNT_W-1:0] col_hi,
   output logic             in_win
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] row_q;
   logic [CNT_W-1:0] col_q;
   logic             hact_d;
   logic             row_ok;
   logic             col_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         hact_d <= 1'b0;
      end else begin
         hact_d <= hact;
         if (!vact)
            row_q <= '0;
         else if (hact_d && !hact && (row_q != CNT_MAX))
            row_q <= row_q + 1'b1;
         if (!hact)
            col_q <= '0;
         else if (vact && (col_q != CNT_MAX))
            col_q <= col_q + 1'b1;
      end
   end

   assign row_ok = !row_en || ((row_q >= row_lo) && (row_q <= row_hi));
   assign col_ok = !col_en || ((col_q >= col_lo) && (col_q <= col_hi));
   assign in_win = row_ok && col_ok;

   // R10
   col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hact |=> (col_q == '0));

   // R10
   row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vact |=> (row_q == '0));

endmodule

// File: rtl/cpf_widen.sv
module cpf_widen
   import cpf_pkg::*;
#(
   parameter int OUT_W = 12
) (
   input  logic [2:0]       bps,
   input  logic             rep,
   input  logic [OUT_W-1:0] din,
   output logic [OUT_W-1:0] dout
);
   always_comb begin
      int sh;
      int w;
      sh   = narrow_by(bps);
      w    = OUT_W - sh;
      dout = '0;
      for (int b = 0; b < OUT_W; b++) begin
         if (b >= sh)
            dout[b] = din[b - sh];
         else
            dout[b] = rep & din[b + w - sh];
      end
   end

endmodule

// File: rtl/cam_par_capture.sv
module cam_par_capture
   import cpf_pkg::*;
#(
   parameter int OUT_W   = 12,
   parameter int CNT_W   = 12,
   parameter int SKIP_W  = 8,
   parameter bit FALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_fpol,
   input  logic              cfg_ppol,
   input  logic              cfg_vpol,
   input  logic              cfg_hpol,
   input  logic              cfg_cont,
   input  logic [2:0]        cfg_bps,
   input  logic              cfg_rep,
   input  logic [SKIP_W-1:0] cfg_skip,
   input  logic              cfg_row_en,
   input  logic              cfg_col_en,
   input  logic [CNT_W-1:0]  cfg_row_lo,
   input  logic [CNT_W-1:0]  cfg_row_hi,
   input  logic [CNT_W-1:0]  cfg_col_lo,
   input  logic [CNT_W-1:0]  cfg_col_hi,
   input  logic [OUT_W-1:0]  pix_in,
   input  logic              vsync_in,
   input  logic              hsync_in,
   input  logic              field_in,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              done
);
   generate
      if ((OUT_W < 8) || (OUT_W > 16)) begin : g_bad_out_w
         $error("OUT_W must lie in 8..16");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2");
      end
      if (SKIP_W < 1) begin : g_bad_skip_w
         $error("SKIP_W must be at least 1");
      end
   endgenerate

   logic [OUT_W-1:0] s_d;
   logic             s_vs, s_hs, s_fld;
   logic             vact, hact, vact_d;
   logic             fstart, fend;
   logic             cap_now, in_win, keep;
   logic [OUT_W-1:0] wide;
   logic             pend_v, pend_sof, first_q;
   logic [OUT_W-1:0] pend_d;

   cpf_sampler #(.DW(OUT_W), .FALL_EN(FALL_EN)) u_smp (
      .clk(clk), .rst_n(rst_n), .ppol(cfg_ppol),
      .d_in(pix_in), .vs_in(vsync_in), .hs_in(hsync_in), .fld_in(field_in),
      .d_q(s_d), .vs_q(s_vs), .hs_q(s_hs), .fld_q(s_fld)
   );

   assign vact   = s_vs ^ cfg_vpol;
   assign hact   = s_hs ^ cfg_hpol;
   assign fstart = vact && !vact_d;
   assign fend   = !vact && vact_d;

   cpf_seq #(.SKIP_W(SKIP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(cfg_mode),
      .cont(cfg_cont), .skip_cfg(cfg_skip), .is_top(!(s_fld ^ cfg_fpol)),
      .fstart(fstart), .fend(fend), .cap_now(cap_now), .done(done)
   );

   cpf_window #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .vact(vact), .hact(hact),
      .row_en(cfg_row_en), .col_en(cfg_col_en),
      .row_lo(cfg_row_lo), .row_hi(cfg_row_hi),
      .col_lo(cfg_col_lo), .col_hi(cfg_col_hi), .in_win(in_win)
   );

   cpf_widen #(.OUT_W(OUT_W)) u_wid (
      .bps(cfg_bps), .rep(cfg_rep), .din(s_d), .dout(wide)
   );

   assign keep = vact && hact && cap_now && in_win;

   // one-pixel hold so the end marker can ride on the last kept pixel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vact_d    <= 1'b0;
         pend_v    <= 1'b0;
         pend_d    <= '0;
         pend_sof  <= 1'b0;
         first_q   <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
      end else begin
         vact_d  <= vact;
         out_eof <= 1'b0;
         if (keep) begin
            out_valid <= pend_v;
            out_data  <= pend_d;
            out_sof   <= pend_v && pend_sof;
            pend_v    <= 1'b1;
            pend_d    <= wide;
            pend_sof  <= first_q || fstart;
            first_q   <= 1'b0;
         end else begin
            if (fstart) first_q <= 1'b1;
            if (fend) begin
               out_valid <= pend_v;
               out_data  <= pend_d;
               out_sof   <= pend_v && pend_sof;
               out_eof   <= pend_v;
               pend_v    <= 1'b0;
            end else begin
               out_valid <= 1'b0;
               out_sof   <= 1'b0;
            end
         end
      end
   end

   // R11
   eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> out_valid);

   // R11
   sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

endmodule

// File: tb/sim_cam_par_capture.sv
module sim_cam_par_capture;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  cfg_mode = '0;
   logic        cfg_fpol = 0, cfg_ppol = 0, cfg_vpol = 0, cfg_hpol = 0;
   logic        cfg_cont = 0, cfg_rep = 0;
   logic [2:0]  cfg_bps = '0;
   logic [7:0]  cfg_skip = '0;
   logic        cfg_row_en = 0, cfg_col_en = 0;
   logic [11:0] cfg_row_lo = '0, cfg_row_hi = '0, cfg_col_lo = '0, cfg_col_hi = '0;
   logic [11:0] pix_in = '0;
   logic        vsync_in = 0, hsync_in = 0, field_in = 0;
   logic        out_valid, out_sof, out_eof, done;
   logic [11:0] out_data;

   int total = 0, bad = 0;
   int n_pix, n_sof, n_eof, n_done, n_done_eof;
   logic [11:0] first_d, last_d, eof_d;
   bit have_first;

   always #(CLK_PERIOD/2) clk = ~clk;

   cam_par_capture u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
      .cfg_fpol(cfg_fpol), .cfg_ppol(cfg_ppol), .cfg_vpol(cfg_vpol),
      .cfg_hpol(cfg_hpol), .cfg_cont(cfg_cont), .cfg_bps(cfg_bps),
      .cfg_rep(cfg_rep), .cfg_skip(cfg_skip), .cfg_row_en(cfg_row_en),
      .cfg_col_en(cfg_col_en), .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
      .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi), .pix_in(pix_in),
      .vsync_in(vsync_in), .hsync_in(hsync_in), .field_in(field_in),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .done(done)
   );

   // {mode[11:9], fpol[8], fields[7:5], n_fields[4:3], first_idx[2:1], done[0]}
   localparam logic [11:0] VEC [11] = '{
      {3'd0, 1'b0, 3'b101, 2'd1, 2'd0, 1'b1},
      {3'd1, 1'b0, 3'b101, 2'd2, 2'd1, 1'b1},
      {3'd2, 1'b0, 3'b010, 2'd2, 2'd1, 1'b1},
      {3'd3, 1'b0, 3'b010, 2'd2, 2'd0, 1'b1},
      {3'd4, 1'b0, 3'b110, 2'd1, 2'd2, 1'b1},
      {3'd5, 1'b0, 3'b000, 2'd0, 2'd0, 1'b0},
      {3'd6, 1'b0, 3'b100, 2'd1, 2'd0, 1'b1},
      {3'd4, 1'b1, 3'b010, 2'd1, 2'd1, 1'b1},
      {3'd1, 1'b1, 3'b010, 2'd2, 2'd1, 1'b1},
      {3'd2, 1'b1, 3'b110, 2'd1, 2'd2, 1'b0},
      {3'd7, 1'b0, 3'b011, 2'd1, 2'd0, 1'b1}
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (!have_first) begin
               first_d    = out_data;
               have_first = 1'b1;
            end
            n_pix++;
            last_d = out_data;
            if (out_sof) n_sof++;
            if (out_eof) begin
               n_eof++;
               eof_d = out_data;
            end
         end
         if (done) begin
            n_done++;
            if (out_eof) n_done_eof++;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic clear_counts();
      n_pix = 0; n_sof = 0; n_eof = 0; n_done = 0; n_done_eof = 0;
      have_first = 1'b0; first_d = '0; last_d = '0; eof_d = '0;
   endtask

   task automatic drive(input bit v, input bit h, input logic [11:0] d);
      @(posedge clk);
      #1;
      vsync_in = v ^ cfg_vpol;
      hsync_in = h ^ cfg_hpol;
      pix_in   = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0);
   endtask

   // kind 0: base + line*8 + col; kind 1: constant a; kind 2: a before the falling edge, b after
   task automatic send_field(input bit fld, input logic [11:0] base, input int kind,
                             input logic [11:0] a, input logic [11:0] b);
      field_in = fld;
      idle(2);
      drive(1'b1, 1'b0, '0);
      drive(1'b1, 1'b0, '0);
      for (int l = 0; l < 4; l++) begin
         for (int c = 0; c < 6; c++) begin
            if (kind == 0) drive(1'b1, 1'b1, base + 12'(l * 8 + c));
            else drive(1'b1, 1'b1, a);
            if (kind == 2) begin
               #6;
               pix_in = b;
            end
         end
         for (int g = 0; g < 3; g++) drive(1'b1, 1'b0, '0);
      end
      drive(1'b1, 1'b0, '0);
      idle(4);
   endtask

   task automatic reset_dut();
      rst_n = 1'b0;
      start = 1'b0;
      cfg_mode = '0; cfg_fpol = 0; cfg_ppol = 0; cfg_vpol = 0; cfg_hpol = 0;
      cfg_cont = 0; cfg_rep = 0; cfg_bps = '0; cfg_skip = '0;
      cfg_row_en = 0; cfg_col_en = 0;
      cfg_row_lo = '0; cfg_row_hi = '0; cfg_col_lo = '0; cfg_col_hi = '0;
      vsync_in = 0; hsync_in = 0; field_in = 0; pix_in = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      clear_counts();
   endtask

   task automatic pulse_start();
      idle(2);
      @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      clear_counts();
   endtask

   task automatic widen_case(input logic [2:0] bps, input bit rep,
                             input logic [11:0] pin, input logic [11:0] exp, input string req);
      reset_dut();
      cfg_bps = bps;
      cfg_rep = rep;
      pulse_start();
      send_field(1'b0, '0, 1, pin, '0);
      idle(4);
      chk({req, " widened first"}, first_d, exp);
      chk({req, " widened last"}, last_d, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state and no capture without start
      reset_dut();
      #4;
      chk("R1 valid after reset", out_valid, 0);
      chk("R1 done after reset", done, 0);
      chk("R1 markers after reset", {out_sof, out_eof}, 0);
      send_field(1'b0, 12'h100, 0, '0, '0);
      idle(4);
      chk("R1 no pixels without start", n_pix, 0);

      // R2 R3 R6 R11: table of mode and field sequences
      for (int i = 0; i < 11; i++) begin
         logic [11:0] v;
         v = VEC[i];
         reset_dut();
         cfg_mode = v[11:9];
         cfg_fpol = v[8];
         pulse_start();
         for (int j = 0; j < 3; j++) send_field(v[7-j], 12'((j + 1) * 256), 0, '0, '0);
         idle(6);
         chk($sformatf("R2/R3 vec%0d fields", i), n_eof, int'(v[4:3]));
         chk($sformatf("R11 vec%0d sof count", i), n_sof, int'(v[4:3]));
         chk($sformatf("R2 vec%0d pixels", i), n_pix, int'(v[4:3]) * 24);
         chk($sformatf("R6 vec%0d done", i), n_done, int'(v[0]));
         chk($sformatf("R6 vec%0d done with eof", i), n_done_eof, int'(v[0]));
         if (v[4:3] != 0) begin
            chk($sformatf("R3 vec%0d first field", i), first_d, (int'(v[2:1]) + 1) * 256);
            chk($sformatf("R11 vec%0d eof on last pixel", i), last_d, eof_d);
         end
      end

      // R6 second start while armed ignored, further fields ignored after done
      reset_dut();
      pulse_start();
      idle(2);
      @(posedge clk); #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
      send_field(1'b0, 12'h100, 0, '0, '0);
      send_field(1'b0, 12'h200, 0, '0, '0);
      idle(4);
      chk("R1 repeated start single unit", n_eof, 1);
      chk("R6 later field ignored", last_d, 12'h100 + 12'd29);

      // R7 continuous with skip of 2
      reset_dut();
      cfg_cont = 1;
      cfg_skip = 8'd2;
      pulse_start();
      for (int j = 0; j < 7; j++) send_field(1'b0, 12'((j + 1) * 256), 0, '0, '0);
      idle(4);
      chk("R7 captured fields", n_eof, 3);
      chk("R7 no done in video mode", n_done, 0);
      chk("R7 last captured is seventh", eof_d, 7 * 256 + 29);

      // R7 continuous without skip
      reset_dut();
      cfg_cont = 1;
      pulse_start();
      for (int j = 0; j < 3; j++) send_field(1'b1, 12'((j + 1) * 256), 0, '0, '0);
      idle(4);
      chk("R7 no skip all fields", n_eof, 3);

      // R4 active-low syncs
      reset_dut();
      cfg_vpol = 1;
      cfg_hpol = 1;
      idle(3);
      pulse_start();
      send_field(1'b0, 12'h100, 0, '0, '0);
      idle(4);
      chk("R4 active-low pixels", n_pix, 24);
      chk("R4 active-low first", first_d, 12'h100);

      // R10 crop both axes, inclusive bounds
      reset_dut();
      cfg_row_en = 1; cfg_row_lo = 12'd1; cfg_row_hi = 12'd2;
      cfg_col_en = 1; cfg_col_lo = 12'd2; cfg_col_hi = 12'd4;
      pulse_start();
      send_field(1'b0, 12'h100, 0, '0, '0);
      idle(4);
      chk("R10 crop pixels", n_pix, 6);
      chk("R10 crop first", first_d, 12'h100 + 12'd10);
      chk("R11 crop eof pixel", eof_d, 12'h100 + 12'd20);

      // R10 row crop only, column window ignored while disabled
      reset_dut();
      cfg_row_en = 1; cfg_row_lo = 12'd3; cfg_row_hi = 12'd9;
      cfg_col_lo = 12'd5; cfg_col_hi = 12'd5;
      pulse_start();
      send_field(1'b0, 12'h100, 0, '0, '0);
      idle(4);
      chk("R10 row crop pixels", n_pix, 6);
      chk("R10 row crop first", first_d, 12'h100 + 12'd24);

      // R8 R9 widening
      widen_case(3'd4, 1'b0, 12'hFA5, 12'hA50, "R8 8-bit zero");
      widen_case(3'd4, 1'b1, 12'hFA5, 12'hA5A, "R9 8-bit rep");
      widen_case(3'd2, 1'b1, 12'hEF3, 12'hBCE, "R9 10-bit rep");
      widen_case(3'd3, 1'b1, 12'hFA5, 12'hD2E, "R9 9-bit rep");
      widen_case(3'd1, 1'b1, 12'hDA5, 12'hB4B, "R9 11-bit rep");
      widen_case(3'd0, 1'b1, 12'h123, 12'h123, "R8 12-bit");
      widen_case(3'd7, 1'b0, 12'h3A5, 12'hA50, "R8 code7 as 8-bit");

      // R5 sampling edge
      reset_dut();
      cfg_ppol = 1;
      pulse_start();
      send_field(1'b0, '0, 2, 12'h111, 12'h222);
      idle(4);
      chk("R5 falling edge first", first_d, 12'h111);
      chk("R5 falling edge last", last_d, 12'h111);
      chk("R5 falling edge pixels", n_pix, 24);
      reset_dut();
      pulse_start();
      send_field(1'b0, '0, 2, 12'h111, 12'h222);
      idle(4);
      chk("R5 rising edge first", first_d, 12'h222);
      chk("R5 rising edge pixels", n_pix, 24);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule